// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps an asynchronous DRAM refreshed. It generates its own CAS-before-RAS (CBR) cycles, so no row address is needed. After reset it waits through the power-up pause and then issues the initial CBR cycles. After that, a free-running interval timer adds one owed refresh per interval. The owed count is presented to the access sequencer as a request. When the sequencer grants the bus, this block drives RAS, CAS and WE directly. It keeps the request up until the precharge that ends the cycle has elapsed, and only then does the sequencer take the bus back.

The sequencer may postpone refreshes. Owed refreshes are counted up to a small saturating limit, and an urgent flag rises once more are owed than may be postponed. The same engine also runs self refresh. A self-refresh request, accepted only while the block is idle after init, enters through a CBR cycle. The block then holds both strobes low for at least the minimum self-refresh time and for as long as the request stays up. On exit it precharges and issues exactly one catch-up CBR cycle.

State machine (`state`): `S_PAUSE` (power-up wait) → `S_IDLE`. From `S_IDLE`, the block goes to `S_REQ` when init is not yet done, when self refresh is requested, or when a refresh is owed. `S_REQ` goes to `S_CAS_LEAD` on grant. `S_CAS_LEAD` (CAS low only) goes to `S_RAS_ACT` (both strobes low). `S_RAS_ACT` goes to `S_PRECHG` for a normal cycle, or to `S_SR_HOLD` in self refresh. `S_PRECHG` goes back to `S_IDLE`. `S_SR_HOLD` goes to `S_SR_EXIT` once the minimum has elapsed and the request has dropped. `S_SR_EXIT` goes to `S_CAS_LEAD`, which starts the catch-up cycle.

Top module: `dram_cbr_refresh`

## Requirements
- R1: Once init is done, one refresh becomes owed every INTERVAL_CYC = CLK_KHZ*WINDOW_MS/ROWS cycles, where ROWS/WINDOW_MS is 8192/128 or 4096/64. While refreshes are owed and grant is given, the block issues on average one CBR cycle per interval.
- R2: In every CBR cycle, cas_n goes low exactly CSR_CYC cycles before ras_n falls and stays low for as long as ras_n is low. In a normal cycle, ras_n stays low for exactly RAS_CYC cycles.
- R3: we_n and oe_n are high in every cycle, so a refresh can never enter test mode and never enables data onto the bus.
- R4: Out of reset, ras_n, cas_n are high and refresh_req, busy, init_done are low. The first strobe appears no earlier than PAUSE_CYC = CLK_KHZ*PAUSE_US/1000 cycles. init_done rises after exactly INIT_CBR CBR cycles and then stays high.
- R5: cas_n never falls while grant is low. busy is high whenever a strobe is low and through the precharge that follows. ras_n stays high for at least RP_CYC cycles before each fall.
- R6: selfref_req has no effect before init_done: no RAS-low period during init lasts longer than RAS_CYC.
- R7: Self refresh starts with a CBR cycle. Both strobes then stay low for at least SR_CYC = CLK_KHZ*SR_MIN_US/1000+1 further cycles and until selfref_req drops. busy and refresh_req stay high throughout.
- R8: On leaving self refresh, ras_n stays high for at least RPS_CYC cycles, and exactly one CBR cycle follows. After that, no further cycle occurs before the next interval.
- R9: The owed count saturates at MAX_POSTPONE+1, and each completed CBR after init retires one owed refresh.
- R10: refresh_urgent is high exactly while more than MAX_POSTPONE refreshes are owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| selfref_req | input | 1 | Level request to stay in self refresh |
| grant | input | 1 | Sequencer hands the DRAM strobes to this block |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| oe_n | output | 1 | Output enable, held high |
| refresh_req | output | 1 | Bus wanted; held until the cycle's precharge is over |
| refresh_urgent | output | 1 | More refreshes owed than may be postponed |
| busy | output | 1 | Strobes are driven by this block |
| init_done | output | 1 | Power-up pause and initial cycles complete |

## Verification
The bench sets CLK_KHZ to 8000 and keeps the 8192-row, 128 ms setting. The refresh interval then shrinks to 125 cycles, and the power-up pause and self-refresh minimum shrink to 800 and 801 cycles. The strobe widths keep their defaults of 2, 13, 8 and 23 cycles, so each CBR cycle is short compared with the interval. This makes the owed-count saturation visible as a fixed burst length after a long postponement. It also leaves a clean gap after the catch-up cycle that follows self refresh. With these values, init, several dozen periodic cycles and two self-refresh episodes fit in a few thousand cycles.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
    typedef enum logic [3:0] {
        S_PAUSE,
        S_IDLE,
        S_REQ,
        S_CAS_LEAD,
        S_RAS_ACT,
        S_PRECHG,
        S_SR_HOLD,
        S_SR_EXIT
    } ref_state_t;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int INTERVAL = 3906
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = $clog2(INTERVAL + 1);
    localparam logic [W-1:0] RELOAD = W'(INTERVAL - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= RELOAD;
        else if (!run || cnt == '0)
            cnt <= RELOAD;
        else
            cnt <= cnt - 1'b1;
    end

    assign tick = run && (cnt == '0);
endmodule

// File: rtl/ref_pending_ctr.sv
module ref_pending_ctr #(
    parameter int MAX_POSTPONE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    input  logic dec,
    output logic owed,
    output logic urgent
);
    localparam int CEIL = MAX_POSTPONE + 1;
    localparam int W = $clog2(CEIL + 1);

    logic [W-1:0] pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend <= '0;
        else if (clear)
            pend <= '0;
        else if (inc && !dec && pend != W'(CEIL))
            pend <= pend + 1'b1;
        else if (dec && !inc && pend != '0)
            pend <= pend - 1'b1;
    end

    assign owed   = (pend != '0);
    assign urgent = (pend > W'(MAX_POSTPONE));
endmodule

// File: rtl/ref_phase_timer.sv
module ref_phase_timer #(
    parameter int W = 8,
    parameter int RESET_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= W'(RESET_VAL);
        else if (load)
            cnt <= load_val - 1'b1;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/dram_cbr_refresh.sv
module dram_cbr_refresh
    import dram_ref_pkg::*;
#(
    parameter int CLK_KHZ      = 250000,
    parameter int ROWS         = 8192,
    parameter int WINDOW_MS    = 128,
    parameter int PAUSE_US     = 100,
    parameter int SR_MIN_US    = 100,
    parameter int INIT_CBR     = 8,
    parameter int CSR_CYC      = 2,
    parameter int RAS_CYC      = 13,
    parameter int RP_CYC       = 8,
    parameter int RPS_CYC      = 23,
    parameter int MAX_POSTPONE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic selfref_req,
    input  logic grant,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic oe_n,
    output logic refresh_req,
    output logic refresh_urgent,
    output logic busy,
    output logic init_done
);
    localparam int INTERVAL_CYC = CLK_KHZ * WINDOW_MS / ROWS;
    localparam int PAUSE_CYC    = CLK_KHZ * PAUSE_US / 1000;
    localparam int SR_CYC       = CLK_KHZ * SR_MIN_US / 1000 + 1;
    localparam int MAX_DLY      = (PAUSE_CYC > SR_CYC) ? PAUSE_CYC : SR_CYC;
    localparam int DLY_W        = $clog2(MAX_DLY + 1);
    localparam int INIT_W       = $clog2(INIT_CBR + 1);

    localparam logic [DLY_W-1:0] D_CSR = DLY_W'(CSR_CYC);
    localparam logic [DLY_W-1:0] D_RAS = DLY_W'(RAS_CYC);
    localparam logic [DLY_W-1:0] D_RP  = DLY_W'(RP_CYC);
    localparam logic [DLY_W-1:0] D_RPS = DLY_W'(RPS_CYC);
    localparam logic [DLY_W-1:0] D_SR  = DLY_W'(SR_CYC);
    localparam logic [DLY_W-1:0] D_ONE = DLY_W'(1);

    ref_state_t        state, next_state;
    logic              sr_mode, sr_take;
    logic [INIT_W-1:0] init_cnt;
    logic              dly_load, dly_done;
    logic [DLY_W-1:0]  dly_val;
    logic              tick, owed, cbr_done, timer_run;

    // next-state logic
    always_comb begin
        next_state = state;
        sr_take    = 1'b0;
        unique case (state)
            S_PAUSE:    if (dly_done) next_state = S_IDLE;
            S_IDLE: begin
                if (!init_done)
                    next_state = S_REQ;
                else if (selfref_req) begin
                    next_state = S_REQ;
                    sr_take    = 1'b1;
                end else if (owed)
                    next_state = S_REQ;
            end
            S_REQ:      if (grant) next_state = S_CAS_LEAD;
            S_CAS_LEAD: if (dly_done) next_state = S_RAS_ACT;
            S_RAS_ACT:  if (dly_done) next_state = sr_mode ? S_SR_HOLD : S_PRECHG;
            S_SR_HOLD:  if (dly_done && !selfref_req) next_state = S_SR_EXIT;
            S_SR_EXIT:  if (dly_done) next_state = S_CAS_LEAD;
            S_PRECHG:   if (dly_done) next_state = S_IDLE;
            default:    next_state = S_PAUSE;
        endcase
    end

    // phase length chosen by the state being entered
    always_comb begin
        dly_load = (next_state != state);
        unique case (next_state)
            S_CAS_LEAD: dly_val = D_CSR;
            S_RAS_ACT:  dly_val = D_RAS;
            S_PRECHG:   dly_val = D_RP;
            S_SR_HOLD:  dly_val = D_SR;
            S_SR_EXIT:  dly_val = D_RPS;
            default:    dly_val = D_ONE;
        endcase
    end

    assign cbr_done  = (state == S_PRECHG) && dly_done;
    assign timer_run = init_done && !sr_mode && (state != S_SR_EXIT);

    // state register and the flags that move with it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_PAUSE;
            sr_mode   <= 1'b0;
            init_cnt  <= '0;
            init_done <= 1'b0;
        end else begin
            state <= next_state;
            if (sr_take)
                sr_mode <= 1'b1;
            else if (state == S_SR_HOLD && next_state == S_SR_EXIT)
                sr_mode <= 1'b0;
            if (cbr_done && !init_done) begin
                init_cnt <= init_cnt + 1'b1;
                if (init_cnt == INIT_W'(INIT_CBR - 1))
                    init_done <= 1'b1;
            end
        end
    end

    // Moore outputs
    always_comb begin
        ras_n       = 1'b1;
        cas_n       = 1'b1;
        we_n        = 1'b1;
        oe_n        = 1'b1;
        refresh_req = 1'b0;
        busy        = 1'b0;
        unique case (state)
            S_PAUSE, S_IDLE: ;
            S_REQ:      refresh_req = 1'b1;
            S_CAS_LEAD: begin cas_n = 1'b0; refresh_req = 1'b1; busy = 1'b1; end
            S_RAS_ACT, S_SR_HOLD: begin
                ras_n = 1'b0; cas_n = 1'b0; refresh_req = 1'b1; busy = 1'b1;
            end
            S_PRECHG, S_SR_EXIT: begin refresh_req = 1'b1; busy = 1'b1; end
            default: ;
        endcase
    end

    ref_interval_timer #(.INTERVAL(INTERVAL_CYC)) u_interval (
        .clk(clk), .rst_n(rst_n), .run(timer_run), .tick(tick)
    );

    ref_pending_ctr #(.MAX_POSTPONE(MAX_POSTPONE)) u_pending (
        .clk(clk), .rst_n(rst_n), .clear(state == S_SR_HOLD),
        .inc(tick), .dec(cbr_done && init_done),
        .owed(owed), .urgent(refresh_urgent)
    );

    ref_phase_timer #(.W(DLY_W), .RESET_VAL(PAUSE_CYC)) u_phase (
        .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(dly_val),
        .expired(dly_done)
    );
endmodule

// File: rtl/dram_cbr_refresh_chk.sv
module dram_cbr_refresh_chk #(
    parameter int CSR_CYC  = 2,
    parameter int RAS_CYC  = 13,
    parameter int RP_CYC   = 8,
    parameter int INIT_CBR = 8
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic grant,
    input logic refresh_req,
    input logic refresh_urgent,
    input logic busy,
    input logic init_done
);
    int unsigned cas_low_run, ras_low_run, ras_high_run, ras_falls;
    logic ras_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cas_low_run  <= 0;
            ras_low_run  <= 0;
            ras_high_run <= 0;
            ras_falls    <= 0;
            ras_prev     <= 1'b1;
        end else begin
            cas_low_run  <= cas_n ? 0 : cas_low_run + 1;
            ras_low_run  <= ras_n ? 0 : ras_low_run + 1;
            ras_high_run <= ras_n ? ras_high_run + 1 : 0;
            ras_prev     <= ras_n;
            if (ras_prev && !ras_n)
                ras_falls <= ras_falls + 1;
        end
    end

    p_cas_leads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && cas_low_run >= CSR_CYC));
    p_cas_covers_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);
    p_ras_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> ras_low_run >= RAS_CYC);
    p_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ras_high_run >= RP_CYC);
    p_strobe_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> busy);
    p_grant_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> grant);
    p_init_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> ras_falls >= INIT_CBR);
    p_init_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    p_urgent_asks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_urgent && !busy) |=> refresh_req);
endmodule

bind dram_cbr_refresh dram_cbr_refresh_chk #(
    .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC), .INIT_CBR(INIT_CBR)
) i_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .grant(grant),
    .refresh_req(refresh_req), .refresh_urgent(refresh_urgent), .busy(busy),
    .init_done(init_done)
);

// File: tb/test_dram_cbr_refresh.sv
`timescale 1ns/1ps
module test_dram_cbr_refresh;
    localparam int CLK_KHZ = 8000;
    localparam int INT_CYC = CLK_KHZ * 128 / 8192;   // 125
    localparam int PAUSE   = CLK_KHZ * 100 / 1000;   // 800
    localparam int SR_MIN  = CLK_KHZ * 100 / 1000 + 1;
    localparam int CSR = 2, RAS = 13, RP = 8, RPS = 23, MAXP = 3;

    // postponement table: {offset from first request, expected urgent}
    localparam int NV = 4;
    localparam int TBL_OFF [NV] = '{3*INT_CYC-3, 3*INT_CYC+1, 5*INT_CYC, 7*INT_CYC};
    localparam bit TBL_URG [NV] = '{1'b0, 1'b1, 1'b1, 1'b1};

    logic clk = 0, rst_n = 0, selfref_req = 0, grant = 0;
    logic ras_n, cas_n, we_n, oe_n, refresh_req, refresh_urgent, busy, init_done;
    bit   auto_grant = 1;
    int   cyc = 0, checks = 0, fails = 0;
    int   cas_low_run = 0, ras_low_run = 0, ras_high_run = 0, last_low = 0, last_high = 0;
    int   falls = 0, rises = 0, first_fall_cyc = -1, rise_cyc = 0;
    int   r3_viol = 0, grant_viol = 0, cover_viol = 0, init_max_low = 0;
    bit   prev_ras = 1, prev_cas = 1;

    dram_cbr_refresh #(.CLK_KHZ(CLK_KHZ)) i_dram_cbr_refresh (
        .clk(clk), .rst_n(rst_n), .selfref_req(selfref_req), .grant(grant),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .refresh_req(refresh_req), .refresh_urgent(refresh_urgent),
        .busy(busy), .init_done(init_done)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // grant follows the request, driven just after each rising edge
    initial forever begin
        @(posedge clk); #1;
        grant = auto_grant & refresh_req;
    end

    // strobe monitor, sampled mid-cycle
    always @(negedge clk) if (rst_n) begin
        if (!we_n || !oe_n) r3_viol++;
        if (!ras_n && cas_n) cover_viol++;
        if (prev_cas && !cas_n && !grant) grant_viol++;
        if (prev_ras && !ras_n) begin
            chk(cas_low_run == CSR, "R2 cas lead", cas_low_run, CSR);
            chk(ras_high_run >= RP, "R5 precharge", ras_high_run, RP);
            last_high = ras_high_run;
            if (first_fall_cyc < 0) first_fall_cyc = cyc;
            falls++;
        end
        if (!prev_ras && ras_n) begin
            last_low = ras_low_run;
            rise_cyc = cyc;
            rises++;
            if (!init_done && ras_low_run > init_max_low) init_max_low = ras_low_run;
            if (ras_low_run < SR_MIN) chk(ras_low_run == RAS, "R2 ras width", ras_low_run, RAS);
        end
        cas_low_run  = cas_n ? 0 : cas_low_run + 1;
        ras_low_run  = ras_n ? 0 : ras_low_run + 1;
        ras_high_run = ras_n ? ras_high_run + 1 : 0;
        prev_ras = ras_n;
        prev_cas = cas_n;
    end

    initial begin
        repeat (30000) @(posedge clk);
        chk(0, "watchdog", cyc, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int rel_cyc, f0, t0, drop_cyc;
        selfref_req = 1;                      // R6: held during init
        repeat (4) @(negedge clk);
        chk(ras_n && cas_n, "R4 reset strobes", {ras_n, cas_n}, 3);
        chk(!refresh_req && !busy && !init_done, "R4 reset flags",
            {refresh_req, busy, init_done}, 0);
        @(negedge clk); rst_n = 1; rel_cyc = cyc;

        while (falls < INIT_CBR_N()) @(negedge clk);
        selfref_req = 0;
        while (!init_done) @(negedge clk);
        chk(first_fall_cyc - rel_cyc >= PAUSE, "R4 pause", first_fall_cyc - rel_cyc, PAUSE);
        chk(falls == 8, "R4 init cycles", falls, 8);
        chk(init_max_low == RAS, "R6 selfref ignored in init", init_max_low, RAS);
        repeat (3) @(negedge clk);
        chk(init_done, "R4 init sticky", init_done, 1);

        // R1 periodic
        f0 = falls;
        repeat (20 * INT_CYC) @(negedge clk);
        chk(falls - f0 >= 19 && falls - f0 <= 21, "R1 rate", falls - f0, 20);

        // R9/R10 postponement table
        while (refresh_req) @(negedge clk);
        auto_grant = 0;
        while (!refresh_req) @(negedge clk);
        t0 = cyc; f0 = falls;
        for (int i = 0; i < NV; i++) begin
            while (cyc < t0 + TBL_OFF[i]) @(negedge clk);
            chk(refresh_urgent == TBL_URG[i], "R10 urgent", refresh_urgent, TBL_URG[i]);
            chk(refresh_req, "R1 request held", refresh_req, 1);
        end
        chk(falls == f0, "R5 no cycle without grant", falls - f0, 0);
        auto_grant = 1;
        repeat (150) @(negedge clk);
        chk(falls - f0 >= 4 && falls - f0 <= 5, "R9 saturated burst", falls - f0, 4);
        chk(!refresh_urgent, "R10 urgent cleared", refresh_urgent, 0);

        // R7/R8 self refresh held long
        while (refresh_req) @(negedge clk);
        selfref_req = 1; f0 = falls;
        while (falls == f0) @(negedge clk);
        repeat (1000) @(negedge clk);
        chk(busy && refresh_req && !ras_n && !cas_n, "R7 holding",
            {busy, refresh_req, ras_n, cas_n}, 12);
        selfref_req = 0; drop_cyc = cyc; f0 = rises;
        while (rises == f0) @(negedge clk);
        chk(rise_cyc > drop_cyc, "R7 exit after drop", rise_cyc, drop_cyc + 1);
        chk(last_low >= RAS + SR_MIN, "R7 long hold", last_low, RAS + SR_MIN);
        f0 = falls; t0 = rise_cyc;
        while (cyc < t0 + 80) @(negedge clk);
        chk(falls - f0 == 1, "R8 one catch-up", falls - f0, 1);
        chk(last_high >= RPS, "R8 exit precharge", last_high, RPS);

        // R7 minimum when request drops early
        while (refresh_req) @(negedge clk);
        selfref_req = 1; f0 = falls;
        while (falls == f0) @(negedge clk);
        repeat (50) @(negedge clk);
        selfref_req = 0; f0 = rises;
        while (rises == f0) @(negedge clk);
        chk(last_low >= RAS + SR_MIN, "R7 minimum", last_low, RAS + SR_MIN);

        chk(r3_viol == 0, "R3 we/oe high", r3_viol, 0);
        chk(cover_viol == 0, "R2 cas covers ras", cover_viol, 0);
        chk(grant_viol == 0, "R5 grant before cas", grant_viol, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    function automatic int INIT_CBR_N();
        return 8;
    endfunction
endmodule